// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the four interrupt causes of a UART and reduces them to one interrupt request line and a 4-bit identification code. The code names the most urgent enabled cause that is pending. The four causes, from most to least urgent, are line-status errors, received data ready, transmit holding register empty, and a change on a modem control input. Line status and received data arrive as levels that the surrounding logic keeps up. The holding-empty cause and the modem-change cause are stored inside the block as sticky flags.

Each stored flag is cleared by its own access rule. The holding-empty flag is cleared by a write to the transmit holding register. It is also cleared by a read of the identification code, but only when that read returns the holding-empty code. The modem-change flag is cleared only by a read of the modem status register. The host logic feeds in the enable bits and the three access strobes, and it returns the identification code as read data.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, with no source pending, `iid` is 4'b0001 and `irq` is 0.
- R2: An enabled line-status condition (`en_line` and `line_stat` both 1) has first priority and gives `iid` = 4'b0110, whatever else is pending.
- R3: An enabled receive-ready condition gives `iid` = 4'b0100 when no enabled line-status condition is present.
- R4: The holding-empty flag is set on a clock edge where `thr_empty` has risen from 0 to 1 while `en_thre` is 1. Holding `thr_empty` at 1 does not set it again. When enabled and set, the flag gives `iid` = 4'b0010 if no higher cause is pending.
- R5: Any bit of `mdm_delta` at 1 on a clock edge sets the modem-change flag. When enabled and set, the flag gives `iid` = 4'b0000 if nothing else is pending.
- R6: `irq` is 1 exactly when some enabled cause is pending. Bit 0 of `iid` is the inverse of `irq`. With nothing pending, `iid` is 4'b0001.
- R7: A cause whose enable input is 0 is never reported in `iid` and does not raise `irq`.
- R8: A pulse on `thr_wr` clears the holding-empty flag from the next cycle on.
- R9: A pulse on `iid_rd` clears the holding-empty flag only if `iid` is 4'b0010 in that cycle. A read that returns a higher-priority code leaves the flag set.
- R10: The modem-change flag is cleared only by `msr_rd`. Pulses on `iid_rd` or `thr_wr` leave it set.
- R11: When a set event and a clear strobe reach the same flag on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_line | input | 1 | Enable for the line-status cause |
| en_rxd | input | 1 | Enable for the receive-ready cause |
| en_thre | input | 1 | Enable for the holding-empty cause |
| en_mdm | input | 1 | Enable for the modem-change cause |
| line_stat | input | 1 | Line-status error condition (level) |
| rx_ready | input | 1 | Received data available (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| mdm_delta | input | MDM_W | One bit per modem input, 1 when that input changed |
| iid_rd | input | 1 | Strobe: identification code is being read |
| thr_wr | input | 1 | Strobe: transmit holding register is being written |
| msr_rd | input | 1 | Strobe: modem status register is being read |
| iid | output | 4 | Identification code of the top pending cause |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. They check that the idle code goes with a low request line and that an enabled line-status condition always wins. They check that each stored flag stays set until its own clear rule fires and falls after a clear strobe that has no competing set. They also check that an identification read that returns a higher-priority code leaves the holding-empty flag alone. Only the bench scenarios show three further behaviours. These are the full priority order across combinations of enables and causes, the rising-edge-only setting of the holding-empty flag, and the set-over-clear outcome when an event and a strobe collide.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int IID_W = 4;
   localparam int NSRC  = 4;

   typedef logic [IID_W-1:0] iid_t;

   localparam iid_t IID_NONE = 4'b0001;
   localparam iid_t IID_LINE = 4'b0110;
   localparam iid_t IID_RXD  = 4'b0100;
   localparam iid_t IID_THRE = 4'b0010;
   localparam iid_t IID_MDM  = 4'b0000;

   // Source index 0 is the most urgent.
   function automatic iid_t code_of(input int idx);
      iid_t c;
      case (idx)
         0:       c = IID_LINE;
         1:       c = IID_RXD;
         2:       c = IID_THRE;
         default: c = IID_MDM;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_d;

   generate
      if (SET_OVER_CLR) begin : g_set_wins
         always_comb begin
            if (set_i)      flag_d = 1'b1;
            else if (clr_i) flag_d = 1'b0;
            else            flag_d = flag_o;
         end
      end else begin : g_clr_wins
         always_comb begin
            if (clr_i)      flag_d = 1'b0;
            else if (set_i) flag_d = 1'b1;
            else            flag_d = flag_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= flag_d;
   end

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   // R8
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uirq_resolve.sv
module uirq_resolve
   import uirq_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] pend_i,
   output iid_t         iid_o,
   output logic         req_o
);
   initial begin
      if (N < 1 || N > NSRC) $error("uirq_resolve: N out of range");
   end

   always_comb begin
      iid_o = IID_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) iid_o = code_of(i);
      end
   end

   assign req_o = |pend_i;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uirq_pkg::*;
#(
   parameter int MDM_W        = 4,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_line,
   input  logic             en_rxd,
   input  logic             en_thre,
   input  logic             en_mdm,
   input  logic             line_stat,
   input  logic             rx_ready,
   input  logic             thr_empty,
   input  logic [MDM_W-1:0] mdm_delta,
   input  logic             iid_rd,
   input  logic             thr_wr,
   input  logic             msr_rd,
   output logic [3:0]       iid,
   output logic             irq
);
   generate
      if (MDM_W < 1) begin : g_bad_mdm
         $error("uart_irq_prio: MDM_W must be at least 1");
      end
   endgenerate

   logic           empty_q;
   logic           thre_set, thre_clr, thre_flag;
   logic           mdm_set, mdm_flag;
   logic [NSRC-1:0] pend;
   iid_t           iid_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q <= 1'b0;
      else        empty_q <= thr_empty;
   end

   assign thre_set = en_thre && thr_empty && !empty_q;
   assign thre_clr = thr_wr || (iid_rd && (iid_w == IID_THRE));
   assign mdm_set  = |mdm_delta;

   uirq_sticky #(.SET_OVER_CLR(SET_OVER_CLR)) thre_flag_i (
      .clk(clk), .rst_n(rst_n), .set_i(thre_set), .clr_i(thre_clr), .flag_o(thre_flag));

   uirq_sticky #(.SET_OVER_CLR(SET_OVER_CLR)) mdm_flag_i (
      .clk(clk), .rst_n(rst_n), .set_i(mdm_set), .clr_i(msr_rd), .flag_o(mdm_flag));

   assign pend[0] = en_line && line_stat;
   assign pend[1] = en_rxd  && rx_ready;
   assign pend[2] = en_thre && thre_flag;
   assign pend[3] = en_mdm  && mdm_flag;

   uirq_resolve #(.N(NSRC)) resolve_i (.pend_i(pend), .iid_o(iid_w), .req_o(irq));

   assign iid = iid_w;

   // R6
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (iid == IID_NONE));

   // R2
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_line && line_stat) |-> (iid == IID_LINE));

   // R9
   iid_rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thre_flag && iid_rd && (iid != IID_THRE) && !thr_wr) |=> thre_flag);

   // R10
   mdm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdm_flag && !msr_rd) |=> mdm_flag);
endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_line = 0, en_rxd = 0, en_thre = 0, en_mdm = 0;
   logic       line_stat = 0, rx_ready = 0, thr_empty = 0;
   logic [3:0] mdm_delta = '0;
   logic       iid_rd = 0, thr_wr = 0, msr_rd = 0;
   logic [3:0] iid;
   logic       irq;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   uart_irq_prio dut_i (
      .clk(clk), .rst_n(rst_n), .en_line(en_line), .en_rxd(en_rxd),
      .en_thre(en_thre), .en_mdm(en_mdm), .line_stat(line_stat),
      .rx_ready(rx_ready), .thr_empty(thr_empty), .mdm_delta(mdm_delta),
      .iid_rd(iid_rd), .thr_wr(thr_wr), .msr_rd(msr_rd), .iid(iid), .irq(irq));

   // {en_line,en_rxd,en_thre,en_mdm, line,rx,thre_evt,mdm_evt, exp_iid}
   localparam logic [11:0] VEC [12] = '{
      12'b1111_1111_0110,
      12'b1111_0111_0100,
      12'b1111_0011_0010,
      12'b1111_0001_0000,
      12'b1111_0000_0001,
      12'b0111_1111_0100,
      12'b0011_1111_0010,
      12'b0001_1111_0000,
      12'b0000_1111_0001,
      12'b1010_0111_0010,
      12'b0100_0011_0001,
      12'b1001_0001_0000
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [3:0] exp_iid);
      logic exp_irq;
      exp_irq = (exp_iid != 4'b0001);
      #1;
      checks++;
      if (iid !== exp_iid) begin
         errors++;
         $display("FAIL %s iid actual=%b expected=%b", tag, iid, exp_iid);
      end
      checks++;
      if (irq !== exp_irq) begin
         errors++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
      end
   endtask

   task automatic thre_edge();
      thr_empty = 1'b0; step();
      thr_empty = 1'b1; step();
   endtask

   task automatic mdm_pulse();
      mdm_delta = 4'b0100; step();
      mdm_delta = '0;
   endtask

   task automatic clear_all();
      line_stat = 0; rx_ready = 0;
      thr_wr = 1; msr_rd = 1; step();
      thr_wr = 0; msr_rd = 0;
   endtask

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(); step();
      check("R1 reset", 4'b0001);
      rst_n = 1'b1;
      step();
      check("R1 after release", 4'b0001);

      // priority table: R2 R3 R4 R5 R6 R7
      foreach (VEC[k]) begin
         {en_line, en_rxd, en_thre, en_mdm} = VEC[k][11:8];
         if (VEC[k][5]) thre_edge();
         if (VEC[k][4]) mdm_pulse();
         line_stat = VEC[k][7];
         rx_ready  = VEC[k][6];
         check($sformatf("R2/R3/R4/R5/R7 vector %0d", k), VEC[k][3:0]);
         {en_line, en_rxd, en_thre, en_mdm} = 4'b1111;
         clear_all();
         check("R6 cleared between vectors", 4'b0001);
      end

      // R4: holding thr_empty high does not set again
      step(); step();
      check("R4 no re-set on steady empty", 4'b0001);

      // R9: read returning higher code keeps the flag
      thre_edge();
      rx_ready = 1;
      check("R9 rx above thre", 4'b0100);
      iid_rd = 1; step(); iid_rd = 0;
      rx_ready = 0;
      check("R9 flag kept after higher read", 4'b0010);
      iid_rd = 1; step(); iid_rd = 0;
      check("R9 read of thre code clears", 4'b0001);

      // R8
      thre_edge();
      check("R8 flag set", 4'b0010);
      thr_wr = 1; step(); thr_wr = 0;
      check("R8 write clears", 4'b0001);

      // R10
      mdm_pulse();
      check("R10 modem set", 4'b0000);
      iid_rd = 1; step(); iid_rd = 0;
      thr_wr = 1; step(); thr_wr = 0;
      check("R10 kept after other strobes", 4'b0000);
      msr_rd = 1; step(); msr_rd = 0;
      check("R10 msr read clears", 4'b0001);

      // R11: set and clear on the same edge
      thr_empty = 0; step();
      thr_empty = 1; thr_wr = 1; step(); thr_wr = 0;
      check("R11 thre set beats write", 4'b0010);
      thr_wr = 1; step(); thr_wr = 0;
      mdm_pulse();
      mdm_delta = 4'b0001; msr_rd = 1; step();
      mdm_delta = '0; msr_rd = 0;
      check("R11 modem set beats read", 4'b0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule